// File: doc/BRIEF.md
# Multi-Role Timestamp Pin Controller

This block runs one bidirectional pad that software can set up in one of four ways. The pad can be left unused and floating. It can drive an internal interrupt line or an internal clock line as a push-pull output. It can also act as a trigger input. In that role the block watches for an active edge and produces two results: a one-cycle trigger pulse that tells the timestamp logic to capture, and a steady level that tells the time counter to stop.

An 8-bit register write port sets the configuration. A write is taken when an address-match input and a write strobe are high in the same cycle. Bits 3:2 of the write data hold the pad mode: 00 is off, 01 is interrupt out, 10 is clock out and 11 is trigger in. Bit 5 holds the input polarity. The other data bits are not used. A battery-mode input turns off the output driver whenever the chip runs from its backup supply.

All logic runs on a single sample clock. The pad input passes through a two-stage synchronizer. Polarity is applied to the synchronized level before edge detection. There is no data stream here, so every pin is a plain control or status pin with no valid/ready handshake.

Top module: `tspin_ctrl`

## Requirements
- R1: After reset the mode is off and the polarity is 0, so pin_oe, pin_o, trig_pulse and stop_req are all 0.
- R2: A configuration write happens only when cfg_wr and cfg_sel are both 1 at a clock edge. It loads the mode from cfg_wdata[3:2] and the polarity from cfg_wdata[5]. The new setting shows at the outputs from the cycle after that edge. A strobe without cfg_sel changes nothing.
- R3: In mode 01, with on_battery low, pin_oe is 1 and pin_o follows int_src in the same cycle.
- R4: In mode 10, with on_battery low, pin_oe is 1 and pin_o follows clk_src in the same cycle.
- R5: While on_battery is 1, pin_oe and pin_o are both 0 in every mode.
- R6: In mode 00 and mode 11, pin_oe and pin_o are 0.
- R7: In every mode other than 11, trig_pulse and stop_req stay 0 whatever level pin_i has.
- R8: In mode 11 with polarity 0, a 0-to-1 change of pin_i that is first sampled at edge k raises trig_pulse for exactly the cycle after edge k+1.
- R9: In mode 11 with polarity 1, a 1-to-0 change of pin_i produces the same single pulse with the same latency.
- R10: In mode 11, stop_req equals the synchronized pin level XOR the polarity, two edges behind pin_i.
- R11: Switching into mode 11 never makes a trigger by itself. The edge history is taken from the current synchronized level, so no pulse appears in the first cycle of input mode.
- R12: An active level that is held produces only one trigger pulse, so trig_pulse is never high in two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | Address match for the configuration register |
| cfg_wdata | input | 8 | Write data; mode in bits 3:2, polarity in bit 5 |
| on_battery | input | 1 | Chip is running from the backup supply |
| int_src | input | 1 | Internal interrupt level to put on the pad |
| clk_src | input | 1 | Internal clock to put on the pad |
| pin_i | input | 1 | Level seen at the pad |
| pin_o | output | 1 | Pad output value |
| pin_oe | output | 1 | Pad output driver enable |
| trig_pulse | output | 1 | One-cycle timestamp trigger |
| stop_req | output | 1 | Stop request to the time counter (active level) |

## Verification
The pad outputs are combinational on the registered mode. The bench therefore expects them in the same cycle for int_src, clk_src and on_battery changes, and one edge after a configuration write. A pin_i change is due at stop_req two edges after it is first sampled, and trig_pulse is high only in the cycle after that second edge. The bench drives every input a fixed time after an edge. A behavioural model keeps a queue of pin samples and a record of the mode in past cycles, and it is compared with the outputs 1 ns after each rising edge. The bench also runs targeted checks at the exact cycles where R8, R9, R11 and R12 decide the result.

// File: rtl/tspin_pkg.sv
package tspin_pkg;
  typedef enum logic [1:0] {
    PM_OFF = 2'b00,
    PM_IRQ = 2'b01,
    PM_CLK = 2'b10,
    PM_IN  = 2'b11
  } pin_mode_e;

  localparam int CFG_DW   = 8;
  localparam int MODE_LSB = 2;
  localparam int POL_BIT  = 5;
  localparam int SYNC_N   = 2;
endpackage

// File: rtl/tspin_cfg_reg.sv
module tspin_cfg_reg
  import tspin_pkg::*;
#(
  parameter int DW      = CFG_DW,
  parameter int MODE_LO = MODE_LSB,
  parameter int POL_POS = POL_BIT
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic          sel,
  input  logic [DW-1:0] wdata,
  output pin_mode_e     mode,
  output logic          pol
);
  localparam int MODE_HI = MODE_LO + 1;

  logic [DW-1:0] unused_wdata;
  assign unused_wdata = wdata;

  logic take;
  assign take = wr & sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode <= PM_OFF;
      pol  <= 1'b0;
    end else if (take) begin
      mode <= pin_mode_e'(wdata[MODE_HI:MODE_LO]);
      pol  <= wdata[POL_POS];
    end
  end
endmodule

// File: rtl/tspin_in_path.sv
module tspin_in_path #(
  parameter int STAGES = tspin_pkg::SYNC_N
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_en,
  input  logic pol,
  input  logic pin_i,
  output logic trig,
  output logic active
);
  logic [STAGES-1:0] sync_q;
  logic              hist_q;
  logic              en_q;
  logic              lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      hist_q <= 1'b0;
      en_q   <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin_i};
      hist_q <= sync_q[STAGES-1];
      en_q   <= in_en;
    end
  end

  // polarity applied to the synchronized level; history kept raw so a
  // polarity change cannot look like an edge
  assign lvl    = sync_q[STAGES-1];
  assign active = in_en & (lvl ^ pol);
  assign trig   = in_en & en_q & (pol ? (hist_q & ~lvl) : (~hist_q & lvl));
endmodule

// File: rtl/tspin_out_mux.sv
module tspin_out_mux
  import tspin_pkg::*;
(
  input  pin_mode_e mode,
  input  logic      on_battery,
  input  logic      int_src,
  input  logic      clk_src,
  output logic      pin_o,
  output logic      pin_oe
);
  logic drv_sel;

  always_comb begin
    drv_sel = 1'b0;
    unique case (mode)
      PM_IRQ:  drv_sel = int_src;
      PM_CLK:  drv_sel = clk_src;
      default: drv_sel = 1'b0;
    endcase
  end

  assign pin_oe = ((mode == PM_IRQ) | (mode == PM_CLK)) & ~on_battery;
  assign pin_o  = pin_oe & drv_sel;
endmodule

// File: rtl/tspin_ctrl.sv
module tspin_ctrl
  import tspin_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic              cfg_sel,
  input  logic [CFG_DW-1:0] cfg_wdata,
  input  logic              on_battery,
  input  logic              int_src,
  input  logic              clk_src,
  input  logic              pin_i,
  output logic              pin_o,
  output logic              pin_oe,
  output logic              trig_pulse,
  output logic              stop_req
);
  pin_mode_e mode_q;
  logic      pol_q;

  tspin_cfg_reg u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (cfg_wr),
    .sel   (cfg_sel),
    .wdata (cfg_wdata),
    .mode  (mode_q),
    .pol   (pol_q)
  );

  tspin_in_path #(.STAGES(SYNC_N)) u_in (
    .clk    (clk),
    .rst_n  (rst_n),
    .in_en  (mode_q == PM_IN),
    .pol    (pol_q),
    .pin_i  (pin_i),
    .trig   (trig_pulse),
    .active (stop_req)
  );

  tspin_out_mux u_out (
    .mode       (mode_q),
    .on_battery (on_battery),
    .int_src    (int_src),
    .clk_src    (clk_src),
    .pin_o      (pin_o),
    .pin_oe     (pin_oe)
  );
endmodule

// File: rtl/tspin_ctrl_chk.sv
module tspin_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode,
  input logic       pol,
  input logic       on_battery,
  input logic       pin_i,
  input logic       pin_o,
  input logic       pin_oe,
  input logic       trig_pulse,
  input logic       stop_req
);
  AST_BATT_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
    on_battery |-> (!pin_oe && !pin_o)); // R5

  AST_OUT_QUIET_IN: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 2'b11) |-> (!trig_pulse && !stop_req)); // R7

  AST_NO_DRIVE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00 || mode == 2'b11) |-> !pin_oe); // R6

  AST_TRIG_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    trig_pulse |=> !trig_pulse); // R12

  AST_TRIG_WITH_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    trig_pulse |-> stop_req); // R10

  AST_RISE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_pulse && !pol) |-> ($past(pin_i, 2) && !$past(pin_i, 3))); // R8

  AST_FALL_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_pulse && pol) |-> (!$past(pin_i, 2) && $past(pin_i, 3))); // R9
endmodule

bind tspin_ctrl tspin_ctrl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mode       (mode_q),
  .pol        (pol_q),
  .on_battery (on_battery),
  .pin_i      (pin_i),
  .pin_o      (pin_o),
  .pin_oe     (pin_oe),
  .trig_pulse (trig_pulse),
  .stop_req   (stop_req)
);

// File: tb/tspin_ctrl_tb.sv
module tspin_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_wr = 1'b0, cfg_sel = 1'b0;
  logic [7:0] cfg_wdata = 8'h00;
  logic       on_battery = 1'b0, int_src = 1'b0, clk_src = 1'b0, pin_i = 1'b0;
  logic       pin_o, pin_oe, trig_pulse, stop_req;

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  tspin_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .on_battery(on_battery), .int_src(int_src),
    .clk_src(clk_src), .pin_i(pin_i), .pin_o(pin_o), .pin_oe(pin_oe),
    .trig_pulse(trig_pulse), .stop_req(stop_req)
  );

  // behavioural reference model
  int m_mode = 0;
  int m_pol = 0;
  int pinq[$];
  int inq[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_pol = 0;
      pinq = '{0, 0, 0};
      inq = '{0};
    end else begin
      pinq.push_back(int'(pin_i));
      if (pinq.size() > 3) void'(pinq.pop_front());
      inq.push_back(m_mode == 3 ? 1 : 0);
      if (inq.size() > 1) void'(inq.pop_front());
      if (cfg_wr && cfg_sel) begin
        m_mode = int'(cfg_wdata[3:2]);
        m_pol = int'(cfg_wdata[5]);
      end
    end
  end

  task automatic chk(input logic act, input logic exp, input string req, input string what);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic model_cmp();
    logic e_oe, e_o, e_tr, e_st, lvl, prv, inn, inp;
    string ro, ri;
    e_oe = (m_mode == 1 || m_mode == 2) && !on_battery;
    e_o  = e_oe && (m_mode == 1 ? int_src : clk_src);
    lvl = pinq[1][0]; prv = pinq[0][0];
    inn = (m_mode == 3); inp = inq[0][0];
    e_st = inn && (lvl ^ m_pol[0]);
    e_tr = inn && inp && (m_pol != 0 ? (prv && !lvl) : (!prv && lvl));
    if (on_battery) ro = "R5";
    else if (m_mode == 1) ro = "R3";
    else if (m_mode == 2) ro = "R4";
    else ro = "R6";
    if (!inn) ri = "R7";
    else if (!inp) ri = "R11";
    else ri = (m_pol != 0) ? "R9" : "R8";
    chk(pin_oe, e_oe, ro, "pin_oe");
    chk(pin_o, e_o, ro, "pin_o");
    chk(trig_pulse, e_tr, ri, "trig_pulse");
    chk(stop_req, e_st, inn ? "R10" : "R7", "stop_req");
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    if (rst_n) model_cmp();
  endtask

  task automatic wr_cfg(input logic sel, input logic [1:0] mode, input logic pol);
    cfg_wr = 1'b1; cfg_sel = sel;
    cfg_wdata = {2'b11, pol, 1'b1, mode, 2'b11};
    tick();
    cfg_wr = 1'b0; cfg_sel = 1'b0; cfg_wdata = 8'h00;
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: actual running expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (3) begin @(posedge clk); #1; pin_i = ~pin_i; end
    #1;
    chk(pin_oe, 1'b0, "R1", "reset pin_oe");
    chk(pin_o, 1'b0, "R1", "reset pin_o");
    chk(trig_pulse, 1'b0, "R1", "reset trig");
    chk(stop_req, 1'b0, "R1", "reset stop");
    rst_n = 1'b1;
    pin_i = 1'b0;
    tick();

    // R2: strobe without address match is ignored
    wr_cfg(1'b0, 2'b01, 1'b0);
    chk(pin_oe, 1'b0, "R2", "unselected write");
    wr_cfg(1'b1, 2'b01, 1'b0);
    chk(pin_oe, 1'b1, "R2", "selected write");
    for (int i = 0; i < 8; i++) begin
      int_src = i[0]; clk_src = i[1]; tick();
    end
    on_battery = 1'b1; tick(); tick();
    chk(pin_oe, 1'b0, "R5", "battery irq mode");
    on_battery = 1'b0;
    wr_cfg(1'b1, 2'b10, 1'b0);
    for (int i = 0; i < 8; i++) begin
      clk_src = ~clk_src; int_src = i[2]; on_battery = (i == 5); tick();
    end
    on_battery = 1'b0;

    // R7: off mode ignores the pad
    wr_cfg(1'b1, 2'b00, 1'b0);
    for (int i = 0; i < 8; i++) begin pin_i = ~pin_i; tick(); end
    pin_i = 1'b0; tick(); tick();

    // R8 rising edge with polarity 0
    wr_cfg(1'b1, 2'b11, 1'b0);
    tick();
    pin_i = 1'b1;
    tick();
    chk(trig_pulse, 1'b0, "R8", "one edge after");
    tick();
    chk(trig_pulse, 1'b1, "R8", "two edges after");
    chk(stop_req, 1'b1, "R10", "active level");
    tick();
    chk(trig_pulse, 1'b0, "R12", "held level");
    repeat (3) tick();
    pin_i = 1'b0; repeat (4) tick();
    chk(stop_req, 1'b0, "R10", "inactive level");

    // R11: enter input mode with the pad already active
    wr_cfg(1'b1, 2'b00, 1'b0);
    pin_i = 1'b1; repeat (3) tick();
    wr_cfg(1'b1, 2'b11, 1'b0);
    chk(trig_pulse, 1'b0, "R11", "entry cycle");
    tick();
    chk(trig_pulse, 1'b0, "R11", "after entry");

    // R9 falling edge with polarity 1, set on entry
    wr_cfg(1'b1, 2'b00, 1'b0);
    wr_cfg(1'b1, 2'b11, 1'b1);
    tick();
    chk(stop_req, 1'b0, "R10", "pol1 high pad");
    pin_i = 1'b0;
    tick(); tick();
    chk(trig_pulse, 1'b1, "R9", "falling edge");
    tick();
    chk(trig_pulse, 1'b0, "R12", "single pulse");
    for (int i = 0; i < 12; i++) begin pin_i = i[1]; tick(); end
    on_battery = 1'b1; tick(); on_battery = 1'b0; tick();

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule